// File: doc/BRIEF.md
# Transmit DMA Error and Idle Status Register

This block collects the error conditions of a group of transmit DMA channels into one write-one-to-clear register. It also publishes a second, read-only word that shows whether each channel has drained. Each channel reports a few raw conditions every cycle:

- its transmit FIFO has signalled full;
- its credit counter is at zero;
- a new command has arrived;
- its command buffer is already occupied;
- its buffers are empty;
- it has no outstanding requests.

Two chip-wide strobes report a host dword-count shortfall and an internal memory address fault.

The block turns these conditions into sticky flags. A credit error means the FIFO said full while credit was still outstanding, which shows the credit scheme has lost sync. A command overrun means a command arrived while the buffer was still full. Software reads the flags through a simple register port and clears them by writing ones. A single interrupt line is raised while any error flag is set. Software polls the idle word after stopping a channel.

Top module: `txdma_err_regs`

## Requirements
- R1: Credit-error flag of channel c (error word bit c, c from 0 to NUM_CH-1) sets when that channel's full indication is high while its credit-zero input is low; a full indication with credit-zero high sets nothing.
- R2: Command-overrun flag of channel c (error word bit 9+c) sets when a new command arrives while that channel's command buffer is full.
- R3: Error word bit 31 sets on an internal address-fault strobe.
- R4: Error word bit 30 sets on a host dword-count shortfall strobe.
- R5: Every error flag stays set until a write to the error word carries 1 in its bit position; a 0 written to a bit leaves it as it was.
- R6: If a set condition and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The status word shows, one cycle after sampling, buffers-empty of channel c in bit 24+c and no-pending-requests of channel c in bit 16+c; its other bits read 0.
- R8: The reserved error-word bits (8 and 17 to 29, plus unused channel bits) read 0, unmapped addresses read 0, and writes to the status word change nothing.
- R9: The interrupt output is high exactly when any error flag is set.
- R10: After reset all flags, the status word and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_full_i | input | NUM_CH | Per-channel transmit FIFO full indication |
| credit_zero_i | input | NUM_CH | Per-channel credit counter equals zero |
| cmd_new_i | input | NUM_CH | Per-channel new command arrival strobe |
| cmd_full_i | input | NUM_CH | Per-channel command buffer occupied |
| bufs_empty_i | input | NUM_CH | Per-channel buffers empty |
| no_pend_i | input | NUM_CH | Per-channel no outstanding requests |
| len_err_i | input | 1 | Host dword-count shortfall strobe |
| addr_err_i | input | 1 | Internal memory address fault strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W | Register write word index |
| wr_data_i | input | 32 | Register write data (ones clear error flags) |
| rd_addr_i | input | ADDR_W | Register read word index |
| rd_data_o | output | 32 | Register read data (combinational) |
| err_irq_o | output | 1 | Error interrupt, high while any flag is set |

## Verification
On every cycle, the embedded assertions check three things about the flags. A set condition always leaves its bit high on the next cycle, even against a clearing write. A bit that is not written with 1 never falls. A bit written with 1 and not set again falls. They also check that the interrupt agrees with the error word whenever that word is read, that reserved error bits read zero, and that the registered status word follows its inputs one cycle later. Only the bench's scenarios show the rest: the exact bit placement of each field, that a full indication with zero credit is harmless, that status-word writes and unmapped reads have no effect, and the reset values. The bench checks these against its behavioural model on every clock.

// File: rtl/txdma_err_pkg.sv
package txdma_err_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_CH    = 8;
   localparam int CREDIT_LO = 0;
   localparam int OVR_LO    = 9;
   localparam int LEN_BIT   = 30;
   localparam int ADDR_BIT  = 31;
   localparam int IDLE_LO   = 16;
   localparam int EMPTY_LO  = 24;

   function automatic logic [WORD_W-1:0] err_mask(input int nch);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int c = 0; c < nch; c++) begin
         m[CREDIT_LO + c] = 1'b1;
         m[OVR_LO + c]    = 1'b1;
      end
      m[LEN_BIT]  = 1'b1;
      m[ADDR_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/txdma_err_decode.sv
module txdma_err_decode
   import txdma_err_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH-1:0] fifo_full_i,
   input  logic [NUM_CH-1:0] credit_zero_i,
   input  logic [NUM_CH-1:0] cmd_new_i,
   input  logic [NUM_CH-1:0] cmd_full_i,
   input  logic              len_err_i,
   input  logic              addr_err_i,
   output logic [WORD_W-1:0] set_o
);
   logic [NUM_CH-1:0] cred_hit;
   logic [NUM_CH-1:0] ovr_hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign cred_hit[c] = fifo_full_i[c] & ~credit_zero_i[c];
      assign ovr_hit[c]  = cmd_new_i[c] & cmd_full_i[c];
   end

   always_comb begin
      set_o                       = '0;
      set_o[CREDIT_LO +: NUM_CH]  = cred_hit;
      set_o[OVR_LO +: NUM_CH]     = ovr_hit;
      set_o[LEN_BIT]              = len_err_i;
      set_o[ADDR_BIT]             = addr_err_i;
   end
endmodule

// File: rtl/txdma_err_sticky.sv
module txdma_err_sticky
   import txdma_err_pkg::*;
#(
   parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_i,
   input  logic [WORD_W-1:0] clr_i,
   output logic [WORD_W-1:0] flags_o
);
   logic [WORD_W-1:0] flags_q;
   logic [WORD_W-1:0] flags_d;

   always_comb flags_d = ((flags_q & ~clr_i) | set_i) & IMPL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags_o = flags_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & IMPL_MASK) != '0) |=> ((flags_q & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK))); // R6

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_q & ($past(flags_q) & ~$past(clr_i))) == ($past(flags_q) & ~$past(clr_i)))); // R5

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R5
endmodule

// File: rtl/txdma_err_status.sv
module txdma_err_status
   import txdma_err_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter bit STS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] bufs_empty_i,
   input  logic [NUM_CH-1:0] no_pend_i,
   output logic [WORD_W-1:0] sts_o
);
   logic [NUM_CH-1:0] empty_v;
   logic [NUM_CH-1:0] idle_v;

   if (STS_REG) begin : g_reg
      logic [NUM_CH-1:0] empty_q;
      logic [NUM_CH-1:0] idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            empty_q <= '0;
            idle_q  <= '0;
         end else begin
            empty_q <= bufs_empty_i;
            idle_q  <= no_pend_i;
         end
      end
      assign empty_v = empty_q;
      assign idle_v  = idle_q;

      AST_STS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (sts_o[EMPTY_LO +: NUM_CH] == $past(bufs_empty_i)
                   && sts_o[IDLE_LO +: NUM_CH] == $past(no_pend_i))); // R7
   end else begin : g_comb
      assign empty_v = bufs_empty_i;
      assign idle_v  = no_pend_i;
   end

   always_comb begin
      sts_o                      = '0;
      sts_o[EMPTY_LO +: NUM_CH]  = empty_v;
      sts_o[IDLE_LO +: NUM_CH]   = idle_v;
   end
endmodule

// File: rtl/txdma_err_regs.sv
module txdma_err_regs
   import txdma_err_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int ADDR_W  = 2,
   parameter int ERR_IDX = 0,
   parameter int STS_IDX = 1,
   parameter bit STS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] fifo_full_i,
   input  logic [NUM_CH-1:0] credit_zero_i,
   input  logic [NUM_CH-1:0] cmd_new_i,
   input  logic [NUM_CH-1:0] cmd_full_i,
   input  logic [NUM_CH-1:0] bufs_empty_i,
   input  logic [NUM_CH-1:0] no_pend_i,
   input  logic              len_err_i,
   input  logic              addr_err_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [31:0]       wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [31:0]       rd_data_o,
   output logic              err_irq_o
);
   localparam logic [WORD_W-1:0] ERR_MASK = err_mask(NUM_CH);
   localparam logic [ADDR_W-1:0] ERR_A    = ADDR_W'(ERR_IDX);
   localparam logic [ADDR_W-1:0] STS_A    = ADDR_W'(STS_IDX);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and 8");
   end
   if (ERR_IDX == STS_IDX) begin : g_bad_map
      $error("error and status words need distinct indices");
   end
   if (ERR_IDX >= (1 << ADDR_W) || STS_IDX >= (1 << ADDR_W)) begin : g_bad_addr
      $error("word index exceeds address range");
   end

   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] clr_vec;
   logic [WORD_W-1:0] flags;
   logic [WORD_W-1:0] sts_word;

   txdma_err_decode #(.NUM_CH(NUM_CH)) u_decode (
      .fifo_full_i  (fifo_full_i),
      .credit_zero_i(credit_zero_i),
      .cmd_new_i    (cmd_new_i),
      .cmd_full_i   (cmd_full_i),
      .len_err_i    (len_err_i),
      .addr_err_i   (addr_err_i),
      .set_o        (set_vec)
   );

   always_comb clr_vec = (wr_en_i && wr_addr_i == ERR_A) ? wr_data_i : '0;

   txdma_err_sticky #(.IMPL_MASK(ERR_MASK)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flags_o(flags)
   );

   txdma_err_status #(.NUM_CH(NUM_CH), .STS_REG(STS_REG)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .bufs_empty_i(bufs_empty_i),
      .no_pend_i   (no_pend_i),
      .sts_o       (sts_word)
   );

   always_comb begin
      if (rd_addr_i == ERR_A)      rd_data_o = flags;
      else if (rd_addr_i == STS_A) rd_data_o = sts_word;
      else                         rd_data_o = '0;
   end

   assign err_irq_o = |flags;

   AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_i == ERR_A) |-> (err_irq_o == (rd_data_o != '0))); // R9

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_i == ERR_A) |-> ((rd_data_o & ~ERR_MASK) == '0)); // R8
endmodule

// File: tb/txdma_err_regs_tb.sv
module txdma_err_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] fifo_full = '0, credit_zero = '0, cmd_new = '0, cmd_full = '0;
   logic [NCH-1:0] bufs_empty = '0, no_pend = '0;
   logic len_err = 1'b0, addr_err = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic err_irq;

   int checks = 0;
   int fails = 0;
   bit [31:0] m_err = '0, m_err_nx = '0, m_sts = '0, m_sts_nx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txdma_err_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .fifo_full_i(fifo_full), .credit_zero_i(credit_zero),
      .cmd_new_i(cmd_new), .cmd_full_i(cmd_full),
      .bufs_empty_i(bufs_empty), .no_pend_i(no_pend),
      .len_err_i(len_err), .addr_err_i(addr_err),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .err_irq_o(err_irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // behavioural next-state from the currently driven inputs
   task automatic model_next();
      bit [31:0] s = '0;
      bit [31:0] c = '0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (fifo_full[ch] && !credit_zero[ch]) s[ch] = 1'b1;
         if (cmd_new[ch] && cmd_full[ch]) s[9 + ch] = 1'b1;
      end
      if (len_err) s[30] = 1'b1;
      if (addr_err) s[31] = 1'b1;
      if (wr_en && wr_addr == 2'd0) c = wr_data;
      m_err_nx = (m_err & ~c) | s;
      m_sts_nx = {bufs_empty, no_pend, 16'h0};
   endtask

   task automatic compare_all();
      check("R9 irq", {31'd0, err_irq}, {31'd0, m_err != 0});
      case (rd_addr)
         2'd0: begin
            check("R1 credit flags", {24'd0, rd_data[7:0]}, {24'd0, m_err[7:0]});
            check("R2 overrun flags", {24'd0, rd_data[16:9]}, {24'd0, m_err[16:9]});
            check("R3 addr fault", {31'd0, rd_data[31]}, {31'd0, m_err[31]});
            check("R4 length fault", {31'd0, rd_data[30]}, {31'd0, m_err[30]});
            check("R8 reserved", rd_data & 32'h3FFE_0100, 32'd0);
         end
         2'd1: check("R7 status word", rd_data, m_sts);
         default: check("R8 unmapped", rd_data, 32'd0);
      endcase
   endtask

   task automatic quiet();
      fifo_full = '0; credit_zero = '0; cmd_new = '0; cmd_full = '0;
      len_err = 1'b0; addr_err = 1'b0; wr_en = 1'b0; wr_data = '0;
   endtask

   // commit model after the edge, then compare at the falling edge
   task automatic step();
      model_next();
      @(negedge clk);
      m_err = m_err_nx;
      m_sts = m_sts_nx;
      compare_all();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rd_addr = 2'd0; #1;
      check("R10 reset error word", rd_data, 32'd0);
      check("R10 reset irq", {31'd0, err_irq}, 32'd0);
      rd_addr = 2'd1; #1;
      check("R10 reset status word", rd_data, 32'd0);
      rst_n = 1'b1;

      // R1: full with zero credit is harmless, full with credit sets bit
      rd_addr = 2'd0;
      quiet(); fifo_full = 8'h0F; credit_zero = 8'h05; step();
      check("R1 directed", rd_data, 32'h0000_000A);
      // R5: writing zeros keeps flags
      quiet(); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0; step();
      check("R5 zero write", rd_data, 32'h0000_000A);
      // R6: clear and set of bit 1 together, clear bit 3
      quiet(); fifo_full = 8'h02; wr_en = 1'b1; wr_data = 32'h0000_000A; step();
      check("R6 set wins", rd_data, 32'h0000_0002);
      // R2, R3, R4
      quiet(); cmd_new = 8'h81; cmd_full = 8'h80; len_err = 1'b1; addr_err = 1'b1; step();
      check("R2 R3 R4 directed", rd_data, 32'hC001_0002);
      // R8: write to status word changes nothing
      quiet(); wr_en = 1'b1; wr_addr = 2'd1; wr_data = '1; step();
      check("R8 status write ignored", rd_data, 32'hC001_0002);
      // R5: clear all with ones
      quiet(); wr_en = 1'b1; wr_addr = 2'd0; wr_data = '1; step();
      check("R5 clear all", rd_data, 32'd0);
      check("R9 irq low", {31'd0, err_irq}, 32'd0);
      // R7 status placement
      quiet(); rd_addr = 2'd1; bufs_empty = 8'hA5; no_pend = 8'h3C; step();
      check("R7 directed", rd_data, 32'hA53C_0000);

      for (int i = 0; i < 4000; i++) begin
         quiet();
         fifo_full   = $urandom_range(0, 255) & $urandom_range(0, 255);
         credit_zero = $urandom_range(0, 255) | $urandom_range(0, 255);
         cmd_new     = $urandom_range(0, 255) & $urandom_range(0, 255) & $urandom_range(0, 255);
         cmd_full    = $urandom_range(0, 255);
         bufs_empty  = $urandom_range(0, 255);
         no_pend     = $urandom_range(0, 255);
         len_err     = ($urandom_range(0, 31) == 0);
         addr_err    = ($urandom_range(0, 31) == 0);
         wr_en       = ($urandom_range(0, 3) == 0);
         wr_addr     = $urandom_range(0, 3);
         wr_data     = $urandom;
         rd_addr     = $urandom_range(0, 3);
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule